// File: doc/BRIEF.md
# Paged MDIO register bridge

This block lets a host read and write 32-bit registers that sit behind a management serial link. The registers use 16-bit byte addresses, and the low two address bits carry no meaning. The link moves only 16 data bits per frame, so each host access becomes a fixed chain of three write-or-read frames on the link. The first frame selects a page taken from the upper address bits. The second frame uses a 4-bit word index, carried in the frame's register field, and moves the low half of the data. The third frame moves the high half.

The host raises a one-cycle request with a direction flag, an address and write data. The block accepts it only when idle and raises `busy`. When the last frame has ended, it pulses `done`, and for a read the assembled 32-bit word is waiting on `rd_data`. On the line side, the block divides the system clock down to a management clock. It drives the data line through an output and an output enable, and it reads the line back through a separate input. The target station address comes from an input and is sampled when a request is accepted.

Top module: `paged_mdio_bridge`

## Requirements
- R1: Out of reset, `busy`, `done`, `mdio_oe`, `mdio_o` and `mdc` are all low.
- R2: Every frame is sent most significant bit first. It starts with exactly PRE_LEN (default 32) driven ones, then start bits 01, a 2-bit opcode, the 5-bit station address from `phy_addr`, a 5-bit register field, a 2-bit turnaround and 16 data bits.
- R3: The first frame of every access is a write frame (opcode 01) with register field 11111. Its 16 data bits are six zeros followed by page = address bits 15:6.
- R4: On a read, the second frame uses opcode 10 with register field {0, address bits 5:2}. The 16 bits returned in it become `rd_data[15:0]`.
- R5: On a read, the third frame uses opcode 10 with register field 10000. The 16 bits returned in it become `rd_data[31:16]`.
- R6: On a write, the second frame uses opcode 01 with register field {0, address bits 5:2} and carries `wr_data[15:0]`. The third frame uses opcode 01 with register field 10000 and carries `wr_data[31:16]`.
- R7: Each access is exactly three frames, always in the order page, low half, high half. `done` rises only after the high-half frame has ended.
- R8: On write frames the turnaround is driven as 10. On read frames `mdio_oe` is low from the turnaround through the end of the data. Input bits are taken at the rising edge of `mdc`.
- R9: `mdc` has a period of 2*MDC_HALF system clocks. `mdio_o` and `mdio_oe` change only together with a falling edge of `mdc`.
- R10: `busy` rises the cycle after a request is accepted and falls in the same cycle that `done` pulses. `done` lasts one cycle. A request made while `busy` is high has no effect on the frames, the result or the frame count.
- R11: Address bits 1:0 do not affect any frame. Addresses that differ only in those bits reach the same register.
- R12: While `busy` is low, `mdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phy_addr | input | 5 | Station address placed in every frame |
| req | input | 1 | One-cycle access request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 16 | Byte address of the 32-bit register |
| wr_data | input | 32 | Data for a write access |
| rd_data | output | 32 | Data assembled by a read access |
| done | output | 1 | One-cycle pulse when an access completes |
| busy | output | 1 | High from acceptance until completion |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
Some properties are checked on every cycle. These are the line-timing rule that the data line moves only with a falling management clock, the release of the line whenever the block is idle, the accept-to-busy step, and the shape of `done` against `busy`. Frame content needs the bench's station model, which decodes the frames on the line. This covers the preamble, field values, page and index split, the three-frame order, turnaround handling and the assembly of the two read halves. The model answers with data and then compares the register values that come back against an independently kept image. Only the bench's scenarios can show that requests made while busy are ignored and that the two low address bits have no effect, because both are judged on a whole access.

// File: rtl/mdio_br_pkg.sv
package mdio_br_pkg;

    localparam int FD_W     = 16;   // data bits per frame
    localparam int RF_W     = 5;    // register field width
    localparam int PHY_W    = 5;    // station address width
    localparam int IDX_W    = 4;    // word index width
    localparam int BODY_W   = 32;   // frame bits after the preamble
    localparam int HDR_BITS = 14;   // start + opcode + station + register
    localparam int DAT_OFS  = 16;   // first data bit position after preamble

    localparam logic [1:0] ST_BITS = 2'b01;
    localparam logic [1:0] OP_WR   = 2'b01;
    localparam logic [1:0] OP_RD   = 2'b10;
    localparam logic [1:0] TA_WR   = 2'b10;

    localparam logic [RF_W-1:0] RF_PAGE = 5'b11111;
    localparam logic [RF_W-1:0] RF_HIGH = 5'b10000;

    typedef enum logic [1:0] {
        PH_PAGE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

endpackage

// File: rtl/mdio_br_clkgen.sv
module mdio_br_clkgen #(
    parameter int MDC_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(MDC_HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } cg_t;

    cg_t st_d, st_q;
    logic wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == CNT_LAST);
        if (wrap) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc       = st_q.mdc;
    assign rise_tick = wrap & ~st_q.mdc;
    assign fall_tick = wrap &  st_q.mdc;

endmodule

// File: rtl/mdio_br_frame_build.sv
module mdio_br_frame_build
    import mdio_br_pkg::*;
#(
    parameter int PAGE_W = 10
) (
    input  phase_e                 phase,
    input  logic                   is_wr,
    input  logic [PAGE_W-1:0]      page,
    input  logic [IDX_W-1:0]       idx,
    input  logic [2*FD_W-1:0]      wdata,
    input  logic [PHY_W-1:0]       phy,
    output logic [BODY_W-1:0]      body,
    output logic                   rd_frame
);
    logic [1:0]       op;
    logic [RF_W-1:0]  rf;
    logic [1:0]       ta;
    logic [FD_W-1:0]  dat;

    always_comb begin
        rd_frame = (phase != PH_PAGE) && !is_wr;
        op       = rd_frame ? OP_RD : OP_WR;
        ta       = rd_frame ? 2'b00 : TA_WR;
        unique case (phase)
            PH_PAGE: begin
                rf  = RF_PAGE;
                dat = FD_W'(page);
            end
            PH_LOW: begin
                rf  = {1'b0, idx};
                dat = wdata[FD_W-1:0];
            end
            default: begin
                rf  = RF_HIGH;
                dat = wdata[2*FD_W-1:FD_W];
            end
        endcase
        if (rd_frame) dat = '0;
        body = {ST_BITS, op, phy, rf, ta, dat};
    end

endmodule

// File: rtl/mdio_br_rx_capture.sv
module mdio_br_rx_capture
    import mdio_br_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                hi_sel,
    input  logic                bit_in,
    output logic [2*FD_W-1:0]   rdata
);
    typedef struct packed {
        logic [FD_W-1:0] hi;
        logic [FD_W-1:0] lo;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (en) begin
            if (hi_sel) cap_d.hi = {cap_q.hi[FD_W-2:0], bit_in};
            else        cap_d.lo = {cap_q.lo[FD_W-2:0], bit_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign rdata = {cap_q.hi, cap_q.lo};

endmodule

// File: rtl/paged_mdio_bridge.sv
module paged_mdio_bridge
    import mdio_br_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int MDC_HALF = 4,
    parameter int PRE_LEN  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [4:0]          phy_addr,
    input  logic                req,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [31:0]         wr_data,
    output logic [31:0]         rd_data,
    output logic                done,
    output logic                busy,
    output logic                mdc,
    output logic                mdio_o,
    output logic                mdio_oe,
    input  logic                mdio_i
);
    localparam int PAGE_W    = ADDR_W - 6;
    localparam int FRAME_LEN = PRE_LEN + BODY_W;
    localparam int BW        = $clog2(FRAME_LEN);
    localparam logic [BW-1:0] BIT_LAST  = BW'(FRAME_LEN - 1);
    localparam logic [BW-1:0] PRE_END   = BW'(PRE_LEN);
    localparam logic [BW-1:0] REL_START = BW'(PRE_LEN + HDR_BITS);
    localparam logic [BW-1:0] DAT_START = BW'(PRE_LEN + DAT_OFS);
    localparam logic [BW-1:0] POS_TOP   = BW'(FRAME_LEN - 1);

    typedef struct packed {
        logic               busy;
        logic               started;
        phase_e             phase;
        logic [BW-1:0]      bcnt;
        logic               is_wr;
        logic [PAGE_W-1:0]  page;
        logic [IDX_W-1:0]   idx;
        logic [31:0]        wdata;
        logic [PHY_W-1:0]   phy;
        logic               done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              rise_tick, fall_tick;
    logic [BODY_W-1:0] body;
    logic              rd_frame;
    logic [BW-1:0]     body_pos;
    logic              line_bit;
    logic              cap_en;

    mdio_br_clkgen #(
        .MDC_HALF (MDC_HALF)
    ) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_br_frame_build #(
        .PAGE_W (PAGE_W)
    ) u_build (
        .phase    (seq_q.phase),
        .is_wr    (seq_q.is_wr),
        .page     (seq_q.page),
        .idx      (seq_q.idx),
        .wdata    (seq_q.wdata),
        .phy      (seq_q.phy),
        .body     (body),
        .rd_frame (rd_frame)
    );

    // sequencer next state
    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (!seq_q.busy) begin
            if (req) begin
                seq_d.busy    = 1'b1;
                seq_d.started = 1'b0;
                seq_d.phase   = PH_PAGE;
                seq_d.bcnt    = '0;
                seq_d.is_wr   = req_write;
                seq_d.page    = req_addr[ADDR_W-1:6];
                seq_d.idx     = req_addr[5:2];
                seq_d.wdata   = wr_data;
                seq_d.phy     = phy_addr;
            end
        end else if (fall_tick) begin
            if (!seq_q.started) begin
                seq_d.started = 1'b1;
                seq_d.phase   = PH_PAGE;
                seq_d.bcnt    = '0;
            end else if (seq_q.bcnt == BIT_LAST) begin
                seq_d.bcnt = '0;
                unique case (seq_q.phase)
                    PH_PAGE: seq_d.phase = PH_LOW;
                    PH_LOW:  seq_d.phase = PH_HIGH;
                    default: begin
                        seq_d.busy    = 1'b0;
                        seq_d.started = 1'b0;
                        seq_d.phase   = PH_PAGE;
                        seq_d.done    = 1'b1;
                    end
                endcase
            end else begin
                seq_d.bcnt = seq_q.bcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.phase <= PH_PAGE;
        end else begin
            seq_q <= seq_d;
        end
    end

    // line driver
    always_comb begin
        body_pos = POS_TOP - seq_q.bcnt;
        if (seq_q.bcnt < PRE_END) line_bit = 1'b1;
        else                      line_bit = body[body_pos[4:0]];
    end

    assign mdio_o  = seq_q.started & line_bit;
    assign mdio_oe = seq_q.started & (~rd_frame | (seq_q.bcnt < REL_START));

    assign cap_en = rise_tick & seq_q.started & rd_frame & (seq_q.bcnt >= DAT_START);

    mdio_br_rx_capture u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cap_en),
        .hi_sel (seq_q.phase == PH_HIGH),
        .bit_in (mdio_i),
        .rdata  (rd_data)
    );

    assign busy = seq_q.busy;
    assign done = seq_q.done;

endmodule

// File: rtl/paged_mdio_bridge_chk.sv
module paged_mdio_bridge_chk (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic busy,
    input logic done,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R10

    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R7

    AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy); // R10

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe); // R12

    AST_LINE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mdio_o) || !$stable(mdio_oe)) |-> $fell(mdc)); // R9

endmodule

bind paged_mdio_bridge paged_mdio_bridge_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .busy    (busy),
    .done    (done),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/paged_mdio_bridge_tb.sv
module paged_mdio_bridge_tb;
    localparam int HALF = 2;
    localparam int PRE  = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  phy_addr = 5'h1F;
    logic        req = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        done, busy, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    paged_mdio_bridge #(
        .ADDR_W   (16),
        .MDC_HALF (HALF),
        .PRE_LEN  (PRE)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .phy_addr  (phy_addr),
        .req       (req),
        .req_write (req_write),
        .req_addr  (req_addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .done      (done),
        .busy      (busy),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    function automatic logic [31:0] dflt(input int key);
        logic [15:0] k = 16'(key);
        return {k ^ 16'hA5C3, ~k};
    endfunction

    // station model: register image kept from line traffic
    logic [31:0] phy_mem [int];
    logic [31:0] exp_mem [int];
    logic [9:0]  m_page = '0;
    logic [3:0]  m_idx = '0;
    logic [15:0] m_lo = '0;
    int          ones = 0;
    int          hstate = 0;
    int          hc = 0;
    int          tc = 0;
    logic [13:0] hdr = '0;
    logic [17:0] tail = '0;
    logic        m_rd = 1'b0;
    logic [15:0] rsp = '0;
    logic        nxt_in = 1'b1;
    bit          cur_pre_ok = 1'b0;
    bit          cur_oe_ok = 1'b1;

    int          nframes = 0;
    logic [1:0]  f_op  [0:3];
    logic [4:0]  f_phy [0:3];
    logic [4:0]  f_reg [0:3];
    logic [15:0] f_dat [0:3];
    logic [1:0]  f_ta  [0:3];
    bit          f_pre [0:3];
    bit          f_oe  [0:3];

    function automatic logic [31:0] mem_rd(input int key);
        if (phy_mem.exists(key)) return phy_mem[key];
        return dflt(key);
    endfunction

    always @(posedge mdc) begin
        case (hstate)
            0: begin
                if (mdio_oe && mdio_o) ones++;
                else if (mdio_oe && !mdio_o && ones >= PRE) begin
                    cur_pre_ok = (ones == PRE);
                    cur_oe_ok  = 1'b1;
                    hdr = 14'b0;
                    hc = 1;
                    hstate = 1;
                    ones = 0;
                end else ones = 0;
            end
            1: begin
                if (!mdio_oe) cur_oe_ok = 1'b0;
                hdr = {hdr[12:0], mdio_o};
                hc++;
                if (hc == 14) begin
                    m_rd = (hdr[11:10] == 2'b10);
                    if (m_rd) begin
                        if (hdr[4] == 1'b0) begin
                            m_idx = hdr[3:0];
                            rsp = mem_rd({m_page, m_idx})[15:0];
                        end else begin
                            rsp = mem_rd({m_page, m_idx})[31:16];
                        end
                    end
                    tc = 0;
                    nxt_in = 1'b1;
                    hstate = 2;
                end
            end
            default: begin
                if (m_rd && mdio_oe) cur_oe_ok = 1'b0;
                if (!m_rd && !mdio_oe) cur_oe_ok = 1'b0;
                tail = {tail[16:0], m_rd ? mdio_i : mdio_o};
                tc++;
                if (tc < 2) nxt_in = 1'b1;
                else if (tc < 18) nxt_in = rsp[15 - (tc - 2)];
                if (tc == 18) begin
                    if (nframes < 4) begin
                        f_op[nframes]  = hdr[11:10];
                        f_phy[nframes] = hdr[9:5];
                        f_reg[nframes] = hdr[4:0];
                        f_dat[nframes] = tail[15:0];
                        f_ta[nframes]  = tail[17:16];
                        f_pre[nframes] = cur_pre_ok && (hdr[13:12] == 2'b01);
                        f_oe[nframes]  = cur_oe_ok;
                    end
                    nframes++;
                    if (!m_rd) begin
                        if (hdr[4:0] == 5'b11111) m_page = tail[9:0];
                        else if (hdr[4] == 1'b0) begin
                            m_idx = hdr[3:0];
                            m_lo = tail[15:0];
                        end else phy_mem[{m_page, m_idx}] = {tail[15:0], m_lo};
                    end
                    nxt_in = 1'b1;
                    hstate = 0;
                end
            end
        endcase
    end

    always @(negedge mdc) mdio_i <= nxt_in;

    task automatic access(input bit wr, input logic [15:0] addr, input logic [31:0] wd,
                          input bit intrude, input string tag);
        int key = {addr[15:6], addr[5:2]};
        logic [31:0] exp;
        logic [31:0] got;
        int waited = 0;
        exp = wr ? wd : (exp_mem.exists(key) ? exp_mem[key] : dflt(key));
        @(negedge clk);
        nframes = 0;
        req = 1'b1; req_write = wr; req_addr = addr; wr_data = wd;
        @(negedge clk);
        req = 1'b0;
        chk(busy === 1'b1, "R10 busy after accept", 64'(busy), 64'd1);
        if (intrude) begin
            repeat (40) @(negedge clk);
            chk(busy === 1'b1, "R10 busy mid access", 64'(busy), 64'd1);
            req = 1'b1; req_write = ~wr; req_addr = ~addr; wr_data = ~wd;
            @(negedge clk);
            req = 1'b0; req_write = 1'b0; req_addr = '0; wr_data = '0;
        end
        while (done !== 1'b1 && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        chk(waited < 5000, "R7 access completes", 64'(waited), 64'd0);
        chk(busy === 1'b0, "R10 busy low with done", 64'(busy), 64'd0);
        got = rd_data;
        if (wr) exp_mem[key] = wd;
        chk(nframes == 3, {tag, " R7 three frames"}, 64'(nframes), 64'd3);
        if (nframes == 3) begin
            for (int f = 0; f < 3; f++) begin
                chk(f_pre[f], "R2 preamble and start", 64'(f_pre[f]), 64'd1);
                chk(f_phy[f] == phy_addr, "R2 station address", 64'(f_phy[f]), 64'(phy_addr));
                chk(f_oe[f], "R8 line direction", 64'(f_oe[f]), 64'd1);
            end
            chk(f_op[0] == 2'b01 && f_reg[0] == 5'b11111, {tag, " R3 page frame header"},
                64'({f_op[0], f_reg[0]}), 64'({2'b01, 5'b11111}));
            chk(f_dat[0] == {6'b0, addr[15:6]}, {tag, " R3 R11 page data"},
                64'(f_dat[0]), 64'({6'b0, addr[15:6]}));
            chk(f_ta[0] == 2'b10, "R8 page turnaround", 64'(f_ta[0]), 64'd2);
            if (wr) begin
                chk(f_op[1] == 2'b01 && f_reg[1] == {1'b0, addr[5:2]}, {tag, " R6 low header"},
                    64'({f_op[1], f_reg[1]}), 64'({2'b01, 1'b0, addr[5:2]}));
                chk(f_op[2] == 2'b01 && f_reg[2] == 5'b10000, {tag, " R6 high header"},
                    64'({f_op[2], f_reg[2]}), 64'({2'b01, 5'b10000}));
                chk({f_dat[2], f_dat[1]} == wd, {tag, " R6 write halves"},
                    64'({f_dat[2], f_dat[1]}), 64'(wd));
                chk(f_ta[1] == 2'b10 && f_ta[2] == 2'b10, "R8 write turnaround",
                    64'({f_ta[1], f_ta[2]}), 64'h0a);
            end else begin
                chk(f_op[1] == 2'b10 && f_reg[1] == {1'b0, addr[5:2]}, {tag, " R4 low header"},
                    64'({f_op[1], f_reg[1]}), 64'({2'b10, 1'b0, addr[5:2]}));
                chk(f_op[2] == 2'b10 && f_reg[2] == 5'b10000, {tag, " R5 high header"},
                    64'({f_op[2], f_reg[2]}), 64'({2'b10, 5'b10000}));
                chk(got[15:0] == exp[15:0], {tag, " R4 low half"}, 64'(got[15:0]), 64'(exp[15:0]));
                chk(got[31:16] == exp[31:16], {tag, " R5 high half"}, 64'(got[31:16]), 64'(exp[31:16]));
            end
        end
        @(negedge clk);
        chk(done === 1'b0, "R10 done one cycle", 64'(done), 64'd0);
        chk(mdio_oe === 1'b0, "R12 idle release", 64'(mdio_oe), 64'd0);
    endtask

    initial begin
        #(180000 * 10);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [9:0] pages [0:2];
        int t0, t1;
        pages[0] = 10'h000; pages[1] = 10'h3FF; pages[2] = 10'h2A5;
        repeat (3) @(negedge clk);
        chk({busy, done, mdio_oe, mdio_o, mdc} === 5'b0, "R1 reset outputs",
            64'({busy, done, mdio_oe, mdio_o, mdc}), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(mdio_oe === 1'b0 && busy === 1'b0, "R12 idle after reset", 64'({mdio_oe, busy}), 64'd0);

        // R9: MDC period measured in system clocks
        @(posedge mdc); t0 = $time;
        @(posedge mdc); t1 = $time;
        chk((t1 - t0) == 2 * HALF * 10, "R9 mdc period", 64'(t1 - t0), 64'(2 * HALF * 10));

        // reads of never-written registers
        for (int i = 0; i < 4; i++)
            access(1'b0, {10'h001, 4'(i * 5), 2'b00}, 32'h0, 1'b0, "fresh read");

        // write sweep: every word index on each page, low address bits varied
        for (int p = 0; p < 3; p++)
            for (int i = 0; i < 16; i++)
                access(1'b1, {pages[p], 4'(i), 2'(i)}, {pages[p], 4'(i), 2'(p), ~pages[p], ~4'(i), 2'(i)},
                       1'b0, "sweep write");

        // read sweep with different low bits (R11)
        for (int p = 0; p < 3; p++)
            for (int i = 0; i < 16; i++)
                access(1'b0, {pages[p], 4'(i), 2'(3 - (i % 4))}, 32'h0, 1'b0, "sweep read R11");

        // requests while busy are ignored
        access(1'b1, {10'h155, 4'h9, 2'b00}, 32'hDEAD_BEEF, 1'b1, "busy write");
        access(1'b0, {10'h155, 4'h9, 2'b00}, 32'h0, 1'b1, "busy read");

        // another station address
        phy_addr = 5'h05;
        access(1'b1, {10'h0F0, 4'h3, 2'b00}, 32'h0123_4567, 1'b0, "phy5 write");
        access(1'b0, {10'h0F0, 4'h3, 2'b10}, 32'h0, 1'b0, "phy5 read");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule